// File: doc/BRIEF.md
# Scheduler-Facing Transfer Handshake for a Wavelet Transform Core

This block is the slave side of the link between a master scheduler and a wavelet transform engine. The master launches a transform with a start pulse. The block then reports that it is occupied and fetches the input words one at a time: it raises a request that carries the index of the word it wants, and the master answers with a one-cycle data strobe. Each strobe carries the sample, an even-parity bit, a transform-size field and a direction flag (forward or inverse).

The block checks every word it receives. It confirms a clean word with an acknowledge pulse and passes it to the core with its index. It rejects a damaged word with a negative acknowledge, and then asks again for the same index, so the master sends that word again. The size and the direction are taken from the first clean word of the transform and are held steady for the core until the next transform. After the last word is confirmed, the block gives a one-cycle end marker and drops its busy indication in that same cycle.

Top module: `wavelet_sched_slave`

## Requirements
- R1: While reset is low and in the first cycle after it rises, busy_o, dreq_o, ack_o, nack_o, end_o and smp_valid_o are 0, and size_o and inv_o are 0.
- R2: A start_i pulse seen at a clock edge while busy_o is 0 makes busy_o and dreq_o 1 in the next cycle, with dreq_idx_o equal to 0.
- R3: A start_i pulse while busy_o is 1 has no effect. The transfer in progress continues with the same requested index, and busy_o stays 1.
- R4: A word is sampled only at a clock edge where xfer_valid_i and dreq_o are both 1. dreq_o is 0 in the cycle that follows. A strobe while dreq_o is 0 produces no acknowledge, no negative acknowledge and no sample.
- R5: A word is clean when the XOR of all bits of xfer_data_i together with xfer_par_i is 0 (even parity over DATA_W+1 bits). Otherwise it is damaged.
- R6: Each sampled word gets exactly one one-cycle pulse, in the cycle right after sampling. That pulse is ack_o for a clean word and nack_o for a damaged one. Neither pulse appears at any other time.
- R7: For a clean word, smp_valid_o is 1 in the same cycle as ack_o, with smp_data_o equal to the sampled word and smp_idx_o equal to its index.
- R8: A damaged word is not passed on (smp_valid_o stays 0). In the cycle after nack_o, dreq_o is 1 again with the same index. After ack_o, the next request carries the index plus one.
- R9: size_o and inv_o take the size field and direction flag of the clean word with index 0 (inv 1 = inverse, 0 = forward). The fields that come with all other words, and with damaged words, are ignored. A transform holds size_o+1 words.
- R10: In the cycle after ack_o for index size_o, end_o is 1 for one cycle and busy_o is 0. A start_i in that cycle or later begins a new transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request from the master |
| xfer_valid_i | input | 1 | Data strobe from the master |
| xfer_data_i | input | DATA_W | Sample word |
| xfer_par_i | input | 1 | Even-parity bit for the word |
| xfer_size_i | input | SIZE_W | Transform size field (word count minus one) |
| xfer_inv_i | input | 1 | Direction flag, 1 = inverse |
| busy_o | output | 1 | Transform in progress |
| dreq_o | output | 1 | Data request to the master |
| dreq_idx_o | output | SIZE_W | Index of the requested word |
| ack_o | output | 1 | Word received cleanly |
| nack_o | output | 1 | Word damaged, resend |
| end_o | output | 1 | End of transform marker |
| smp_valid_o | output | 1 | Sample valid toward the core |
| smp_data_o | output | DATA_W | Accepted sample |
| smp_idx_o | output | SIZE_W | Index of the accepted sample |
| size_o | output | SIZE_W | Latched transform size |
| inv_o | output | 1 | Latched direction flag |

## Verification
A directed transform with a damaged second word shows that a retry keeps its index while a clean word advances it. A start pulse sent in the middle of that transform shows that a restart is refused. Changing the size and direction fields on later words shows that only the fields sent with index 0 are latched. A one-word transform whose first copy is damaged covers the smallest count and shows that the size is not latched from a rejected word. A final transform with random word damage and a random master response delay compares every output against a behavioural model, cycle by cycle.

// File: rtl/wsi_pkg.sv
// Shared types for the scheduler handshake slave.
// Assumes: nothing beyond the standard language.
package wsi_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_RESP = 2'd2
    } phase_t;
endpackage

// File: rtl/hs_parity_chk.sv
// Judges a received word clean when data and parity bit hold an even count of ones.
// Assumes: the parity bit travels with the word in the same cycle.
module hs_parity_chk #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              par_i,
    output logic              ok_o
);
    // Combined XOR of all received bits must be zero.
    always_comb ok_o = ~((^word_i) ^ par_i);
endmodule

// File: rtl/hs_ctrl.sv
// Sequencer for the handshake: start, per-word request, ack/nack response, end marker.
// Assumes: last_idx_i is valid from the response cycle of the index-0 word onward.
module hs_ctrl
    import wsi_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic             word_ok_i,
    input  logic [IDX_W-1:0] last_idx_i,
    output logic             busy_o,
    output logic             req_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             take_o,
    output logic             ack_o,
    output logic             nack_o,
    output logic             end_o
);
    phase_t           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             ack_q, nack_q, end_q;

    // Phase decode toward the master and the capture stage.
    always_comb begin
        busy_o = (phase_q != PH_IDLE);
        req_o  = (phase_q == PH_REQ);
        take_o = (phase_q == PH_REQ) && valid_i;
    end

    // Phase, index and one-cycle response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            ack_q   <= 1'b0;
            nack_q  <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            ack_q  <= 1'b0;
            nack_q <= 1'b0;
            end_q  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_REQ;
                        idx_q   <= '0;
                    end
                end
                PH_REQ: begin
                    if (valid_i) begin
                        phase_q <= PH_RESP;
                        ack_q   <= word_ok_i;
                        nack_q  <= ~word_ok_i;
                    end
                end
                PH_RESP: begin
                    if (ack_q && (idx_q == last_idx_i)) begin
                        phase_q <= PH_IDLE;
                        end_q   <= 1'b1;
                    end else begin
                        if (ack_q) idx_q <= idx_q + 1'b1;
                        phase_q <= PH_REQ;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign idx_o  = idx_q;
    assign ack_o  = ack_q;
    assign nack_o = nack_q;
    assign end_o  = end_q;

    // A sampled word is answered by exactly one response pulse next cycle.
    assert_one_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (ack_o ^ nack_o));
    // A response pulse only follows a sampled word.
    assert_resp_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o || nack_o) |-> $past(take_o));
    // The request drops while the response is pending.
    assert_req_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !req_o);
    // A rejected word is requested again at the same index.
    assert_retry_same_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |=> (req_o && (idx_o == $past(idx_o))));
    // The end marker follows a final acknowledge and coincides with idle.
    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> (!busy_o && $past(ack_o)));
endmodule

// File: rtl/hs_capture.sv
// Registers accepted samples for the core and latches size/direction from index 0.
// Assumes: take_i is a one-cycle strobe, ok_i and idx_i are valid with it.
module hs_capture #(
    parameter int DATA_W = 16,
    parameter int SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              ok_i,
    input  logic [SIZE_W-1:0] idx_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              inv_i,
    output logic              smp_valid_o,
    output logic [DATA_W-1:0] smp_data_o,
    output logic [SIZE_W-1:0] smp_idx_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              inv_o
);
    logic accept;
    logic first_word;

    // Clean word sampled this cycle, and whether it opens the transform.
    always_comb begin
        accept     = take_i && ok_i;
        first_word = accept && (idx_i == '0);
    end

    // Sample stream register toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid_o <= 1'b0;
            smp_data_o  <= '0;
            smp_idx_o   <= '0;
        end else begin
            smp_valid_o <= accept;
            if (accept) begin
                smp_data_o <= data_i;
                smp_idx_o  <= idx_i;
            end
        end
    end

    // Transform parameters held from the first clean word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_o <= '0;
            inv_o  <= 1'b0;
        end else if (first_word) begin
            size_o <= size_i;
            inv_o  <= inv_i;
        end
    end

    // Parameters change only when a clean index-0 word was sampled.
    assert_param_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(first_word) |-> ($stable(size_o) && $stable(inv_o)));
endmodule

// File: rtl/wavelet_sched_slave.sv
// Slave handshake between a master scheduler and a wavelet transform core.
// Assumes: master holds a strobe for one cycle and only answers an active request;
// transform length is size field + 1 words.
module wavelet_sched_slave #(
    parameter int DATA_W = 16,
    parameter int SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              xfer_valid_i,
    input  logic [DATA_W-1:0] xfer_data_i,
    input  logic              xfer_par_i,
    input  logic [SIZE_W-1:0] xfer_size_i,
    input  logic              xfer_inv_i,
    output logic              busy_o,
    output logic              dreq_o,
    output logic [SIZE_W-1:0] dreq_idx_o,
    output logic              ack_o,
    output logic              nack_o,
    output logic              end_o,
    output logic              smp_valid_o,
    output logic [DATA_W-1:0] smp_data_o,
    output logic [SIZE_W-1:0] smp_idx_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              inv_o
);
    localparam int IDX_W = SIZE_W;

    logic word_ok;
    logic take;

    hs_parity_chk #(.DATA_W(DATA_W)) u_par (
        .word_i (xfer_data_i),
        .par_i  (xfer_par_i),
        .ok_o   (word_ok)
    );

    hs_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .valid_i    (xfer_valid_i),
        .word_ok_i  (word_ok),
        .last_idx_i (size_o),
        .busy_o     (busy_o),
        .req_o      (dreq_o),
        .idx_o      (dreq_idx_o),
        .take_o     (take),
        .ack_o      (ack_o),
        .nack_o     (nack_o),
        .end_o      (end_o)
    );

    hs_capture #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .ok_i        (word_ok),
        .idx_i       (dreq_idx_o),
        .data_i      (xfer_data_i),
        .size_i      (xfer_size_i),
        .inv_i       (xfer_inv_i),
        .smp_valid_o (smp_valid_o),
        .smp_data_o  (smp_data_o),
        .smp_idx_o   (smp_idx_o),
        .size_o      (size_o),
        .inv_o       (inv_o)
    );

    // A sample reaches the core only together with its acknowledge.
    assert_sample_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (ack_o && !nack_o));
    // A refused start leaves the transform running.
    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !end_o && !(ack_o && dreq_idx_o == size_o)) |=> busy_o);
endmodule

// File: tb/wavelet_sched_slave_tb_top.sv
module wavelet_sched_slave_tb_top;
    localparam int DW = 16;
    localparam int SW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          xfer_valid_i = 1'b0;
    logic [DW-1:0] xfer_data_i = '0;
    logic          xfer_par_i = 1'b0;
    logic [SW-1:0] xfer_size_i = '0;
    logic          xfer_inv_i = 1'b0;
    logic          busy_o, dreq_o, ack_o, nack_o, end_o, smp_valid_o, inv_o;
    logic [SW-1:0] dreq_idx_o, smp_idx_o, size_o;
    logic [DW-1:0] smp_data_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit compare_on = 1'b0;

    wavelet_sched_slave #(.DATA_W(DW), .SIZE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .xfer_valid_i(xfer_valid_i), .xfer_data_i(xfer_data_i),
        .xfer_par_i(xfer_par_i), .xfer_size_i(xfer_size_i),
        .xfer_inv_i(xfer_inv_i), .busy_o(busy_o), .dreq_o(dreq_o),
        .dreq_idx_o(dreq_idx_o), .ack_o(ack_o), .nack_o(nack_o),
        .end_o(end_o), .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o),
        .smp_idx_o(smp_idx_o), .size_o(size_o), .inv_o(inv_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 waiting for a word, 2 answering.
    int m_ph = 0, m_idx = 0, m_size = 0, m_inv = 0;
    bit e_ack = 0, e_nack = 0, e_end = 0, e_sv = 0;
    int e_sd = 0, e_si = 0;
    int accepted[$];

    always @(posedge clk) begin
        bit was_ack;
        bit good;
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_size = 0; m_inv = 0;
            e_ack = 0; e_nack = 0; e_end = 0; e_sv = 0;
        end else begin
            was_ack = e_ack;
            e_ack = 0; e_nack = 0; e_end = 0; e_sv = 0;
            if (m_ph == 0) begin
                if (start_i) begin m_ph = 1; m_idx = 0; end
            end else if (m_ph == 1) begin
                if (xfer_valid_i) begin
                    good = ((^{xfer_data_i, xfer_par_i}) == 1'b0);
                    m_ph = 2;
                    e_ack = good; e_nack = !good;
                    if (good) begin
                        e_sv = 1; e_sd = int'(xfer_data_i); e_si = m_idx;
                        accepted.push_back(int'(xfer_data_i));
                        if (m_idx == 0) begin
                            m_size = int'(xfer_size_i); m_inv = int'(xfer_inv_i);
                        end
                    end
                end
            end else begin
                if (was_ack && m_idx == m_size) begin m_ph = 0; e_end = 1; end
                else begin
                    if (was_ack) m_idx++;
                    m_ph = 1;
                end
            end
        end
    end

    // Every-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check(busy_o == (m_ph != 0), "R2 R10", "busy_o", busy_o, m_ph != 0);
            check(dreq_o == (m_ph == 1), "R4", "dreq_o", dreq_o, m_ph == 1);
            if (m_ph == 1)
                check(int'(dreq_idx_o) == m_idx, "R8", "dreq_idx_o", dreq_idx_o, m_idx);
            check(ack_o == e_ack, "R4 R6", "ack_o", ack_o, e_ack);
            check(nack_o == e_nack, "R4 R6", "nack_o", nack_o, e_nack);
            check(end_o == e_end, "R10", "end_o", end_o, e_end);
            check(smp_valid_o == e_sv, "R7", "smp_valid_o", smp_valid_o, e_sv);
            if (e_sv) begin
                check(int'(smp_data_o) == e_sd, "R7", "smp_data_o", smp_data_o, e_sd);
                check(int'(smp_idx_o) == e_si, "R7", "smp_idx_o", smp_idx_o, e_si);
            end
            check(int'(size_o) == m_size, "R9", "size_o", size_o, m_size);
            check(int'(inv_o) == m_inv, "R9", "inv_o", inv_o, m_inv);
        end
    end

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Called at a negedge: pulse start for one edge.
    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Master answer to the next request; returns at the response cycle.
    task automatic send_word(input logic [DW-1:0] d, input bit corrupt,
                             input int sz, input bit inv, input int delay);
        while (!dreq_o) @(negedge clk);
        repeat (delay) @(negedge clk);
        xfer_valid_i = 1'b1;
        xfer_data_i  = d;
        xfer_par_i   = (^d) ^ corrupt;
        xfer_size_i  = SW'(sz);
        xfer_inv_i   = inv;
        @(negedge clk);
        xfer_valid_i = 1'b0;
        xfer_size_i  = '0;
        xfer_inv_i   = 1'b0;
        check(ack_o == !corrupt, "R5", "ack_o after parity", ack_o, !corrupt);
        check(nack_o == corrupt, "R5", "nack_o after parity", nack_o, corrupt);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(!busy_o && !dreq_o && !ack_o && !nack_o && !end_o && !smp_valid_o,
              "R1", "control outputs after reset", int'({busy_o, dreq_o, ack_o, nack_o, end_o, smp_valid_o}), 0);
        check(size_o == '0 && inv_o == 1'b0, "R1", "latched fields after reset",
              int'(size_o), 0);
        compare_on = 1'b1;

        // Strobe while idle is ignored.
        xfer_valid_i = 1'b1; xfer_data_i = 16'h00FF; xfer_par_i = 1'b0;
        @(negedge clk);
        xfer_valid_i = 1'b0;
        @(negedge clk);
        check(!ack_o && !nack_o && !smp_valid_o, "R4", "response to idle strobe",
              int'({ack_o, nack_o, smp_valid_o}), 0);

        // Transform A: four words, inverse, with one damaged copy and a refused start.
        pulse_start();
        check(busy_o && dreq_o && dreq_idx_o == '0, "R2", "busy/req/idx after start",
              int'({busy_o, dreq_o}), 3);
        send_word(16'hA5A5, 1'b0, 3, 1'b1, 0);
        send_word(16'h1234, 1'b1, 9, 1'b0, 1);
        send_word(16'h1234, 1'b0, 9, 1'b0, 0);
        pulse_start();
        check(busy_o && dreq_o && int'(dreq_idx_o) == 2, "R3", "index after refused start",
              int'(dreq_idx_o), 2);
        send_word(16'h0001, 1'b0, 7, 1'b0, 2);
        send_word(16'hFFFE, 1'b0, 0, 1'b0, 0);
        check(end_o && !busy_o, "R10", "end marker with busy low",
              int'({end_o, busy_o}), 2);
        check(int'(size_o) == 3 && inv_o == 1'b1, "R9", "size/direction from word 0",
              int'(size_o), 3);

        // Transform B: single word, first copy damaged, started in the end cycle.
        pulse_start();
        send_word(16'h0F0F, 1'b1, 5, 1'b1, 0);
        check(int'(size_o) == 3, "R9", "size not taken from damaged word", int'(size_o), 3);
        send_word(16'h0F0E, 1'b0, 0, 1'b0, 0);
        check(end_o && !busy_o && size_o == '0 && !inv_o, "R10", "one-word transform end",
              int'({end_o, busy_o}), 2);
        @(negedge clk);
        check(!end_o, "R10", "end marker width", end_o, 0);

        // Transform C: six words, random damage and master delay.
        pulse_start();
        for (int i = 0; i < 6; ) begin
            bit c;
            c = ($urandom_range(0, 2) == 0);
            send_word(DW'($urandom), c, (i == 0) ? 5 : int'($urandom_range(0, 1023)),
                      (i == 0) ? 1'b1 : 1'($urandom), int'($urandom_range(0, 3)));
            if (!c) i++;
        end
        check(end_o && !busy_o, "R10", "random transform end", int'({end_o, busy_o}), 2);
        check(accepted.size() == 11, "R7", "total clean words delivered", accepted.size(), 11);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule